// File: doc/BRIEF.md
# Integer ALU Execute Stage

This block is the integer execute stage of a 32-bit load/store RISC core. Each cycle in which `issue` is high it accepts one 32-bit instruction word. It reads the two source operands from an internal 32-entry register file. It decodes the register-register or register-immediate form and computes the result. It then commits that result to the register file and shows it on registered result ports. Register 0 always reads as zero and ignores writes.

The operations are add and subtract, each in a trapping and a wrapping variant, the four bitwise operations, signed and unsigned set-less-than, fixed and variable shifts, the immediate forms and load-upper. A trapping add or subtract that overflows in signed terms raises an overflow flag and does not write its destination. An encoding the block does not implement raises a reserved-instruction flag and does not write anything.

Because the register file is included, a sequence of instructions can build operand values and inspect them through the result port. Handling the exceptions is left to the surrounding core.

Top module: `alu_exec_core`

## Requirements
- R1: In the cycle after a synchronous reset, `res_valid`, `res_wen`, `ovf_exc` and `rsvd_exc` are all low.
- R2: The outputs for an instruction sampled at a rising edge with `issue` high appear after that same edge. The register write happens at that edge too, so an instruction issued in the very next cycle already reads the new value.
- R3: With opcode (bits 31:26) equal to 0, the function field (bits 5:0) selects the operation: 0x20 add (trapping), 0x21 add (wrapping), 0x22 subtract (trapping), 0x23 subtract (wrapping), 0x24 and, 0x25 or, 0x26 xor, 0x27 nor. The operand registers are in bits 25:21 (first) and 20:16 (second), and the destination is in bits 15:11.
- R4: When a trapping add, subtract or add-immediate (opcode 8) overflows in signed terms, `ovf_exc` is high, `res_wen` is low and the destination keeps its old value. The wrapping forms (function 0x21, function 0x23, opcode 9) write the modulo-2^32 result and leave `ovf_exc` low.
- R5: Function 0x2a is a signed less-than and function 0x2b an unsigned less-than. Opcode 10 compares against the sign-extended immediate as signed values. Opcode 11 sign-extends its immediate and then compares unsigned. The result is always 0 or 1.
- R6: The fixed shifts (function 0x00 left, 0x02 right logical, 0x03 right arithmetic) shift the register in bits 20:16 by the amount in bits 10:6.
- R7: The variable shifts (function 0x04 left, 0x06 right logical, 0x07 right arithmetic) shift the register in bits 25:21 by bits 4:0 of the register in bits 20:16, and the upper bits of that register are ignored. A right logical shift fills with zeros, and a right arithmetic shift fills with bit 31 of the operand.
- R8: The immediate forms take the 16-bit immediate from bits 15:0 and write the register in bits 20:16. Opcodes 8 and 9 sign-extend the immediate. The logical forms, opcode 12 (and), 13 (or) and 14 (xor), zero-extend it.
- R9: Opcode 15 writes the immediate into bits 31:16 of the result and zeros into bits 15:0.
- R10: Register 0 reads as zero, and a result whose destination is register 0 has `res_wen` low. The all-zero word therefore executes with no effect.
- R11: Any other opcode, or any other function code under opcode 0, raises `rsvd_exc`, keeps `res_wen` low and changes no register.
- R12: After a cycle without `issue`, `res_valid`, `res_wen`, `ovf_exc` and `rsvd_exc` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| res_valid | output | 1 | An instruction completed at the last edge |
| res_wen | output | 1 | That instruction wrote its destination |
| res_dest | output | 5 | Destination register index |
| res_data | output | 32 | Computed result |
| ovf_exc | output | 1 | Signed overflow on a trapping add or subtract |
| rsvd_exc | output | 1 | Unimplemented encoding |

## Verification
Every result and flag is due exactly one rising edge after the edge that sampled `issue`. The register write lands on that same edge, so an instruction issued in the next cycle sees it. The bench drives each instruction on a falling edge and waits for the following rising edge. It then samples the ports a short time later, well before the next edge, so each check reads the outputs of exactly one instruction. Register contents, including those an overflowing or reserved instruction must leave alone, are read back by issuing an OR with register 0 whose destination is register 0. That read disturbs nothing.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int DW = 32;
  localparam int IMMW = 16;

  // major opcodes
  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_ADDIU = 6'd9;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_XORI  = 6'd14;
  localparam logic [5:0] OPC_LUI   = 6'd15;

  // function codes under OPC_REG
  localparam logic [5:0] FN_SHL   = 6'h00;
  localparam logic [5:0] FN_SHR   = 6'h02;
  localparam logic [5:0] FN_SHA   = 6'h03;
  localparam logic [5:0] FN_SHLV  = 6'h04;
  localparam logic [5:0] FN_SHRV  = 6'h06;
  localparam logic [5:0] FN_SHAV  = 6'h07;
  localparam logic [5:0] FN_ADDT  = 6'h20;
  localparam logic [5:0] FN_ADDW  = 6'h21;
  localparam logic [5:0] FN_SUBT  = 6'h22;
  localparam logic [5:0] FN_SUBW  = 6'h23;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;
  localparam logic [5:0] FN_XOR   = 6'h26;
  localparam logic [5:0] FN_NOR   = 6'h27;
  localparam logic [5:0] FN_LTS   = 6'h2a;
  localparam logic [5:0] FN_LTU   = 6'h2b;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_LTS, OP_LTU, OP_SHL, OP_SHR, OP_SHA, OP_HIGH
  } alu_op_e;

  typedef struct packed {
    alu_op_e       op;
    logic          use_imm;   // second operand is the extended immediate
    logic          sh_fixed;  // shift amount from the instruction field
    logic          trap_ovf;  // signed overflow suppresses the write
    logic          illegal;   // unimplemented encoding
    logic [4:0]    dst;
    logic [DW-1:0] imm;
  } dec_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_exec_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] f_rt;
  logic [4:0] f_rd;
  logic [IMMW-1:0] f_imm;
  logic [DW-1:0] imm_sx;
  logic [DW-1:0] imm_zx;

  assign opc    = instr[31:26];
  assign fn     = instr[5:0];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign f_imm  = instr[15:0];
  assign imm_sx = {{(DW-IMMW){f_imm[IMMW-1]}}, f_imm};
  assign imm_zx = {{(DW-IMMW){1'b0}}, f_imm};

  always_comb begin
    dec = '0;
    dec.op  = OP_ADD;
    dec.dst = f_rt;
    dec.imm = imm_sx;
    unique case (opc)
      OPC_REG: begin
        dec.dst = f_rd;
        unique case (fn)
          FN_SHL:  begin dec.op = OP_SHL; dec.sh_fixed = 1'b1; end
          FN_SHR:  begin dec.op = OP_SHR; dec.sh_fixed = 1'b1; end
          FN_SHA:  begin dec.op = OP_SHA; dec.sh_fixed = 1'b1; end
          FN_SHLV: dec.op = OP_SHL;
          FN_SHRV: dec.op = OP_SHR;
          FN_SHAV: dec.op = OP_SHA;
          FN_ADDT: begin dec.op = OP_ADD; dec.trap_ovf = 1'b1; end
          FN_ADDW: dec.op = OP_ADD;
          FN_SUBT: begin dec.op = OP_SUB; dec.trap_ovf = 1'b1; end
          FN_SUBW: dec.op = OP_SUB;
          FN_AND:  dec.op = OP_AND;
          FN_OR:   dec.op = OP_OR;
          FN_XOR:  dec.op = OP_XOR;
          FN_NOR:  dec.op = OP_NOR;
          FN_LTS:  dec.op = OP_LTS;
          FN_LTU:  dec.op = OP_LTU;
          default: dec.illegal = 1'b1;
        endcase
      end
      OPC_ADDI:  begin dec.op = OP_ADD; dec.use_imm = 1'b1; dec.trap_ovf = 1'b1; end
      OPC_ADDIU: begin dec.op = OP_ADD; dec.use_imm = 1'b1; end
      OPC_SLTI:  begin dec.op = OP_LTS; dec.use_imm = 1'b1; end
      OPC_SLTIU: begin dec.op = OP_LTU; dec.use_imm = 1'b1; end
      OPC_ANDI:  begin dec.op = OP_AND; dec.use_imm = 1'b1; dec.imm = imm_zx; end
      OPC_ORI:   begin dec.op = OP_OR;  dec.use_imm = 1'b1; dec.imm = imm_zx; end
      OPC_XORI:  begin dec.op = OP_XOR; dec.use_imm = 1'b1; dec.imm = imm_zx; end
      OPC_LUI:   begin dec.op = OP_HIGH; dec.use_imm = 1'b1; dec.imm = imm_zx; end
      default:   dec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_regfile.sv
module alu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] mem [NREG];

  // no reset on the array so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  dec_t            d,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [SHW-1:0]  sa,
  output logic [XLEN-1:0] res,
  output logic            sgn_ovf
);

  logic [XLEN-1:0] b;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] dif;
  logic [XLEN-1:0] sh_src;
  logic [SHW-1:0]  sh_amt;
  logic            lt_s;
  logic            lt_u;

  assign b      = d.use_imm ? d.imm[XLEN-1:0] : rt_val;
  assign sum    = rs_val + b;
  assign dif    = rs_val - b;
  assign lt_s   = $signed(rs_val) < $signed(b);
  assign lt_u   = rs_val < b;
  assign sh_src = d.sh_fixed ? rt_val : rs_val;
  assign sh_amt = d.sh_fixed ? sa : rt_val[SHW-1:0];

  always_comb begin
    sgn_ovf = 1'b0;
    unique case (d.op)
      OP_ADD:  begin
        res = sum;
        sgn_ovf = (rs_val[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != rs_val[XLEN-1]);
      end
      OP_SUB:  begin
        res = dif;
        sgn_ovf = (rs_val[XLEN-1] != b[XLEN-1]) && (dif[XLEN-1] != rs_val[XLEN-1]);
      end
      OP_AND:  res = rs_val & b;
      OP_OR:   res = rs_val | b;
      OP_XOR:  res = rs_val ^ b;
      OP_NOR:  res = ~(rs_val | b);
      OP_LTS:  res = {{(XLEN-1){1'b0}}, lt_s};
      OP_LTU:  res = {{(XLEN-1){1'b0}}, lt_u};
      OP_SHL:  res = sh_src << sh_amt;
      OP_SHR:  res = sh_src >> sh_amt;
      OP_SHA:  res = $unsigned($signed(sh_src) >>> sh_amt);
      OP_HIGH: res = {d.imm[IMMW-1:0], {(XLEN-IMMW){1'b0}}};
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [31:0]     instr,
  output logic            res_valid,
  output logic            res_wen,
  output logic [AW-1:0]   res_dest,
  output logic [XLEN-1:0] res_data,
  output logic            ovf_exc,
  output logic            rsvd_exc
);

  dec_t            dec;
  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic [XLEN-1:0] alu_res;
  logic            sgn_ovf;
  logic            trap_hit;
  logic            commit;

  alu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  alu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (commit),
    .waddr   (dec.dst[AW-1:0]),
    .wdata   (alu_res),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  alu_unit #(.XLEN(XLEN)) u_alu (
    .d       (dec),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .sa      (instr[6 +: SHW]),
    .res     (alu_res),
    .sgn_ovf (sgn_ovf)
  );

  assign trap_hit = dec.trap_ovf && sgn_ovf;
  assign commit   = issue && !dec.illegal && !trap_hit && (dec.dst[AW-1:0] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_wen   <= 1'b0;
      res_dest  <= '0;
      res_data  <= '0;
      ovf_exc   <= 1'b0;
      rsvd_exc  <= 1'b0;
    end else begin
      res_valid <= issue;
      res_wen   <= commit;
      res_dest  <= dec.dst[AW-1:0];
      res_data  <= alu_res;
      ovf_exc   <= issue && !dec.illegal && trap_hit;
      rsvd_exc  <= issue && dec.illegal;
    end
  end

  // R2
  result_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> res_valid);
  // R4
  ovf_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_exc |-> !res_wen);
  // R11
  rsvd_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_exc |-> (!res_wen && !ovf_exc));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_wen || ovf_exc || rsvd_exc));
  // R10
  zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_dest == '0) |-> !res_wen);
  // R9
  high_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !dec.illegal && dec.op == OP_HIGH) |-> (alu_res[IMMW-1:0] == '0));
  // R5
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !dec.illegal && (dec.op == OP_LTS || dec.op == OP_LTU))
      |-> (alu_res[XLEN-1:1] == '0));

endmodule

// File: tb/alu_exec_core_bench.sv
`timescale 1ns/1ps
module alu_exec_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [31:0] instr = '0;
  logic        res_valid, res_wen, ovf_exc, rsvd_exc;
  logic [4:0]  res_dest;
  logic [31:0] res_data;
  int tests = 0;
  int failed = 0;

  always #2 clk = ~clk;

  alu_exec_core u_alu_exec_core (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr),
    .res_valid(res_valid), .res_wen(res_wen), .res_dest(res_dest),
    .res_data(res_data), .ovf_exc(ovf_exc), .rsvd_exc(rsvd_exc)
  );

  function automatic logic [31:0] rty(input logic [5:0] fn, input logic [4:0] s,
                                      input logic [4:0] t, input logic [4:0] d,
                                      input logic [4:0] sh);
    return {6'd0, s, t, d, sh, fn};
  endfunction

  function automatic logic [31:0] ity(input logic [5:0] op, input logic [4:0] s,
                                      input logic [4:0] t, input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, sample just after the next rising edge
  task automatic exec(input logic [31:0] w);
    @(negedge clk);
    issue = 1'b1;
    instr = w;
    @(posedge clk);
    #1;
    issue = 1'b0;
  endtask

  task automatic setreg(input logic [4:0] r, input logic [31:0] v);
    exec(ity(6'd15, 5'd0, r, v[31:16]));
    exec(ity(6'd13, r, r, v[15:0]));
  endtask

  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    exec(rty(6'h25, r, 5'd0, 5'd0, 5'd0));
    v = res_data;
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'd0, res_valid}, 32'd0);
    chk("R1 wen",   {31'd0, res_wen},   32'd0);
    chk("R1 flags", {30'd0, ovf_exc, rsvd_exc}, 32'd0);
  endtask

  task automatic t_regops;
    setreg(5'd2, 32'd20);
    setreg(5'd3, 32'd30);
    setreg(5'd4, 32'd40);
    exec(rty(6'h20, 5'd2, 5'd3, 5'd1, 5'd0));
    chk("R3 add data", res_data, 32'd50);
    chk("R3 add dest", {27'd0, res_dest}, 32'd1);
    chk("R2 add wen", {31'd0, res_wen}, 32'd1);
    exec(rty(6'h22, 5'd4, 5'd1, 5'd1, 5'd0));
    chk("R2 back-to-back sub", res_data, 32'hfffffff6);
    setreg(5'd5, 32'h0f0f00ff);
    setreg(5'd6, 32'h00ff0f0f);
    exec(rty(6'h24, 5'd5, 5'd6, 5'd7, 5'd0));
    chk("R3 and", res_data, 32'h000f000f);
    exec(rty(6'h25, 5'd5, 5'd6, 5'd7, 5'd0));
    chk("R3 or", res_data, 32'h0fff0fff);
    exec(rty(6'h26, 5'd5, 5'd6, 5'd7, 5'd0));
    chk("R3 xor", res_data, 32'h0ff00ff0);
    exec(rty(6'h27, 5'd0, 5'd0, 5'd7, 5'd0));
    chk("R3 nor", res_data, 32'hffffffff);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    setreg(5'd8, 32'h7fffffff);
    setreg(5'd9, 32'd1);
    exec(ity(6'd8, 5'd0, 5'd10, 16'd3755));
    exec(rty(6'h20, 5'd8, 5'd9, 5'd10, 5'd0));
    chk("R4 add ovf flag", {31'd0, ovf_exc}, 32'd1);
    chk("R4 add ovf wen", {31'd0, res_wen}, 32'd0);
    peek(5'd10, v);
    chk("R4 add ovf dest kept", v, 32'd3755);
    exec(rty(6'h21, 5'd8, 5'd9, 5'd11, 5'd0));
    chk("R4 addu wrap", res_data, 32'h80000000);
    chk("R4 addu no flag", {31'd0, ovf_exc, res_wen}, 32'd1);
    setreg(5'd12, 32'h80000000);
    exec(rty(6'h22, 5'd12, 5'd9, 5'd10, 5'd0));
    chk("R4 sub ovf flag", {31'd0, ovf_exc}, 32'd1);
    peek(5'd10, v);
    chk("R4 sub ovf dest kept", v, 32'd3755);
    exec(rty(6'h23, 5'd12, 5'd9, 5'd13, 5'd0));
    chk("R4 subu wrap", res_data, 32'h7fffffff);
    chk("R4 subu no flag", {31'd0, ovf_exc}, 32'd0);
    exec(ity(6'd8, 5'd8, 5'd10, 16'd1));
    chk("R4 addi ovf flag", {30'd0, ovf_exc, res_wen}, 32'd2);
    exec(ity(6'd9, 5'd8, 5'd14, 16'd1));
    chk("R4 addiu wrap", res_data, 32'h80000000);
    exec(ity(6'd8, 5'd9, 5'd15, 16'hffff));
    chk("R8 addi sign-extended", res_data, 32'd0);
    chk("R8 addi no flag", {31'd0, ovf_exc}, 32'd0);
  endtask

  task automatic t_compare;
    exec(ity(6'd8, 5'd0, 5'd16, 16'hffff));
    exec(rty(6'h2a, 5'd16, 5'd9, 5'd17, 5'd0));
    chk("R5 slt signed", res_data, 32'd1);
    exec(rty(6'h2b, 5'd16, 5'd9, 5'd17, 5'd0));
    chk("R5 sltu unsigned", res_data, 32'd0);
    exec(ity(6'd10, 5'd9, 5'd17, 16'd20));
    chk("R5 slti", res_data, 32'd1);
    exec(ity(6'd10, 5'd16, 5'd17, 16'd0));
    chk("R5 slti negative", res_data, 32'd1);
    exec(ity(6'd11, 5'd9, 5'd17, 16'hffff));
    chk("R5 sltiu sext", res_data, 32'd1);
    exec(ity(6'd11, 5'd16, 5'd17, 16'hffff));
    chk("R5 sltiu equal", res_data, 32'd0);
  endtask

  task automatic t_fixed_shift;
    exec(ity(6'd8, 5'd0, 5'd18, 16'hfff9));
    exec(rty(6'h02, 5'd0, 5'd18, 5'd19, 5'd1));
    chk("R6 srl 1", res_data, 32'h7ffffffc);
    exec(rty(6'h03, 5'd0, 5'd18, 5'd19, 5'd1));
    chk("R6 sra 1", res_data, 32'hfffffffc);
    exec(rty(6'h00, 5'd0, 5'd18, 5'd19, 5'd3));
    chk("R6 sll 3", res_data, 32'hffffffc8);
    exec(rty(6'h02, 5'd0, 5'd18, 5'd19, 5'd3));
    chk("R6 srl 3", res_data, 32'h1fffffff);
  endtask

  task automatic t_var_shift;
    exec(ity(6'd8, 5'd0, 5'd20, 16'h0023));
    exec(rty(6'h04, 5'd18, 5'd20, 5'd21, 5'd0));
    chk("R7 sllv low bits", res_data, 32'hffffffc8);
    exec(rty(6'h06, 5'd18, 5'd20, 5'd21, 5'd0));
    chk("R7 srlv", res_data, 32'h1fffffff);
    exec(rty(6'h07, 5'd18, 5'd20, 5'd21, 5'd0));
    chk("R7 srav", res_data, 32'hffffffff);
  endtask

  task automatic t_imm;
    exec(ity(6'd12, 5'd5, 5'd22, 16'hfff0));
    chk("R8 andi zext", res_data, 32'h000000f0);
    chk("R8 dest is rt", {27'd0, res_dest}, 32'd22);
    exec(ity(6'd13, 5'd0, 5'd22, 16'hffff));
    chk("R8 ori zext", res_data, 32'h0000ffff);
    exec(ity(6'd14, 5'd5, 5'd22, 16'hffff));
    chk("R8 xori zext", res_data, 32'h0f0fff00);
    exec(ity(6'd9, 5'd0, 5'd22, 16'hffff));
    chk("R8 addiu sext", res_data, 32'hffffffff);
    exec(ity(6'd15, 5'd0, 5'd23, 16'h1234));
    chk("R9 lui", res_data, 32'h12340000);
  endtask

  task automatic t_zero_reg;
    logic [31:0] v;
    exec(ity(6'd8, 5'd0, 5'd0, 16'd5));
    chk("R10 r0 write wen", {31'd0, res_wen}, 32'd0);
    peek(5'd0, v);
    chk("R10 r0 reads zero", v, 32'd0);
    exec(32'h0000_0000);
    chk("R10 nop", {29'd0, res_valid, res_wen, rsvd_exc}, 32'd4);
    exec(rty(6'h20, 5'd0, 5'd9, 5'd24, 5'd0));
    chk("R10 r0 operand", res_data, 32'd1);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    exec(ity(6'h3f, 5'd8, 5'd9, 16'h1234));
    chk("R11 bad opcode", {30'd0, rsvd_exc, res_wen}, 32'd2);
    peek(5'd9, v);
    chk("R11 rt untouched", v, 32'd1);
    exec(rty(6'h01, 5'd8, 5'd8, 5'd9, 5'd0));
    chk("R11 bad function", {30'd0, rsvd_exc, res_wen}, 32'd2);
    peek(5'd9, v);
    chk("R11 rd untouched", v, 32'd1);
  endtask

  task automatic t_idle;
    exec(rty(6'h20, 5'd8, 5'd9, 5'd10, 5'd0));
    @(negedge clk);
    @(posedge clk);
    #1;
    chk("R12 idle", {28'd0, res_valid, res_wen, ovf_exc, rsvd_exc}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_regops();
    t_overflow();
    t_compare();
    t_fixed_shift();
    t_var_shift();
    t_imm();
    t_zero_reg();
    t_reserved();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule